// File: doc/BRIEF.md
# Nyquist-Null Modulo Precoder

This block sits in a PAM transmitter, just before the DAC. It turns each incoming symbol index into an odd-integer amplitude level. It subtracts the output of a fixed feedback filter that runs over the precoded samples already sent. It then folds the result back into a bounded window with modulo arithmetic. The folded samples come out spectrally flat. The spectral shaping is applied on the far side of the link, where the receive equalizer adapts toward the same target response.

The target response is the product of a fixed factor (1 + z^-1) and a short monic polynomial G(z) with small integer coefficients. The (1 + z^-1) factor puts a zero at half the symbol rate, so the equalized link behaves as a channel with no excess bandwidth. The coefficients of G(z) are taken from an input bus when reset is left and are not changed afterwards. A bypass input sends mapped levels straight to the output, with no feedback and no folding. Samples are in two's complement with FRAC fractional bits. Symbols arrive under a valid strobe, and each one produces a result one cycle later.

Top module: `thp_precoder`

## Requirements
- R1: Index i is mapped to the level 2i-(M-1), scaled by 2^FRAC (M=12, FRAC=4: index 0 gives -176, index 11 gives 176). Any index above M-1 is treated as M-1.
- R2: `dac_valid_o` is high exactly in the cycle after a cycle with `sym_valid_i` high, and low otherwise. In a cycle with no valid symbol, `dac_data_o` keeps its value.
- R3: In precode mode the output is wrap(x - sum over k=1..NG of h_k*y[n-k]), where y[n-k] are the earlier outputs. The taps are h_k = g_k + g_(k-1), with g_0 = 1 and g_NG = 0. Coefficient g_k (k = 1..NG-1) is a signed TAP_W-bit field at `tap_i[k*TAP_W-1 -: TAP_W]`.
- R4: A precoded output lies in [-M*2^FRAC, M*2^FRAC). It differs from the unfolded value by a multiple of 2M*2^FRAC. A value equal to +M*2^FRAC maps to -M*2^FRAC.
- R5: With `bypass_i` high (bypass mode), the output equals the mapped level of R1, with no feedback term and no folding.
- R6: The filter history advances only on valid symbols, and it stores the emitted output in either mode. A precoded symbol that follows bypassed symbols uses those bypassed outputs as its history.
- R7: While `rst_n` is low, both outputs are zero. Leaving reset clears the history and loads the coefficients from `tap_i`, so a new coefficient set applies after each reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low reset: asynchronous assert, synchronous release |
| tap_i | input | (NG-1)*TAP_W | Signed coefficients g_1..g_(NG-1), loaded when reset is left |
| bypass_i | input | 1 | 1 = pass mapped level, 0 = precode |
| sym_valid_i | input | 1 | Symbol index valid this cycle |
| sym_idx_i | input | clog2(M) | PAM symbol index |
| dac_valid_o | output | 1 | Output sample valid |
| dac_data_o | output | clog2(M)+FRAC+1 | Signed precoded sample, FRAC fractional bits |

## Verification
The riskiest case is a mode switch that lands on a valid symbol whose feedback reads history written in the other mode. It is provoked by placing a bypassed symbol between precoded ones, both with zero coefficients and with a non-trivial set, and by leaving gap cycles around them. The result is judged by comparing each output with a bench reference built from the folding formula. That reference is fed by the outputs it predicted, so an error in either the history update or the mode choice shows up on the next precoded sample.

// File: rtl/thp_pkg.sv
package thp_pkg;

  typedef enum logic {
    MODE_PRECODE = 1'b0,
    MODE_BYPASS  = 1'b1
  } thp_mode_e;

  // Signed width that holds [-m*2^frac, m*2^frac)
  function automatic int thp_out_w(input int m, input int frac);
    return $clog2(m) + frac + 1;
  endfunction

endpackage

// File: rtl/thp_symbol_map.sv
module thp_symbol_map #(
  parameter int M     = 12,
  parameter int FRAC  = 4,
  parameter int IDX_W = 4,
  parameter int OUT_W = 9
) (
  input  logic [IDX_W-1:0]        idx_i,
  output logic signed [OUT_W-1:0] level_o
);

  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(M - 1);

  logic [IDX_W-1:0]        idx_sat;
  logic signed [OUT_W-1:0] odd_lvl;

  always_comb begin
    idx_sat = (idx_i > IDX_MAX) ? IDX_MAX : idx_i;
    odd_lvl = OUT_W'($signed({1'b0, idx_sat, 1'b0})) - OUT_W'(M - 1);
    level_o = odd_lvl <<< FRAC;
  end

endmodule

// File: rtl/thp_feedback_fir.sv
module thp_feedback_fir #(
  parameter int NG    = 8,
  parameter int TAP_W = 4,
  parameter int Y_W   = 9,
  parameter int FB_W  = 19
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [(NG-1)*TAP_W-1:0]   tap_i,
  input  logic                      shift_en_i,
  input  logic signed [Y_W-1:0]     y_i,
  output logic signed [FB_W-1:0]    fb_o
);

  localparam int H_W = TAP_W + 1;
  localparam int P_W = Y_W + H_W;

  // coefficient capture on first edge after reset release
  logic                    loaded_q, loaded_d;
  logic [(NG-1)*TAP_W-1:0] g_q, g_d;

  always_comb begin
    loaded_d = 1'b1;
    g_d      = loaded_q ? g_q : tap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      g_q      <= '0;
    end else begin
      loaded_q <= loaded_d;
      g_q      <= g_d;
    end
  end

  // G(z) coefficients with implicit monic head and zero tail
  logic signed [TAP_W-1:0] g_c [0:NG];
  logic signed [H_W-1:0]   h_c [1:NG];
  logic signed [Y_W-1:0]   hist_q [1:NG];
  logic signed [Y_W-1:0]   hist_d [1:NG];
  logic signed [P_W-1:0]   prod [1:NG];

  assign g_c[0]  = TAP_W'(1);
  assign g_c[NG] = '0;

  for (genvar k = 1; k < NG; k++) begin : g_coef
    assign g_c[k] = g_q[k*TAP_W-1 -: TAP_W];
  end

  // H(z) = (1 + z^-1) G(z)
  for (genvar k = 1; k <= NG; k++) begin : g_tap
    assign h_c[k]  = H_W'(g_c[k]) + H_W'(g_c[k-1]);
    assign prod[k] = P_W'(h_c[k]) * P_W'(hist_q[k]);
  end

  always_comb begin
    fb_o = '0;
    for (int k = 1; k <= NG; k++) begin
      fb_o = fb_o + FB_W'(prod[k]);
    end
  end

  always_comb begin
    for (int k = 1; k <= NG; k++) begin
      hist_d[k] = hist_q[k];
    end
    if (shift_en_i) begin
      hist_d[1] = y_i;
      for (int k = 2; k <= NG; k++) begin
        hist_d[k] = hist_q[k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= NG; k++) begin
        hist_q[k] <= '0;
      end
    end else begin
      for (int k = 1; k <= NG; k++) begin
        hist_q[k] <= hist_d[k];
      end
    end
  end

endmodule

// File: rtl/thp_modulo_reduce.sv
module thp_modulo_reduce #(
  parameter int M      = 12,
  parameter int FRAC   = 4,
  parameter int V_W    = 20,
  parameter int OUT_W  = 9,
  parameter int STAGES = 2
) (
  input  logic signed [V_W-1:0]   v_i,
  output logic signed [OUT_W-1:0] y_o
);

  localparam int HALF = M << FRAC;

  logic signed [V_W-1:0] chain [0:STAGES];

  assign chain[STAGES] = v_i;

  // binary-weighted folding, largest multiple of 2M first
  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int STEP = (2 * HALF) << s;
    localparam logic signed [V_W-1:0] STEP_V = V_W'(STEP);
    localparam logic signed [V_W-1:0] TH_V   = V_W'(STEP - HALF);

    logic signed [V_W-1:0] stg_o;

    always_comb begin
      if (chain[s+1] >= TH_V) begin
        stg_o = chain[s+1] - STEP_V;
      end else if (chain[s+1] < -TH_V) begin
        stg_o = chain[s+1] + STEP_V;
      end else begin
        stg_o = chain[s+1];
      end
    end

    assign chain[s] = stg_o;
  end

  assign y_o = OUT_W'(chain[0]);

endmodule

// File: rtl/thp_precoder.sv
module thp_precoder
  import thp_pkg::*;
#(
  parameter int M          = 12,
  parameter int FRAC       = 4,
  parameter int NG         = 8,
  parameter int TAP_W      = 4,
  parameter int MOD_STAGES = 2,
  localparam int IDX_W     = $clog2(M),
  localparam int OUT_W     = thp_out_w(M, FRAC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [(NG-1)*TAP_W-1:0]   tap_i,
  input  logic                      bypass_i,
  input  logic                      sym_valid_i,
  input  logic [IDX_W-1:0]          sym_idx_i,
  output logic                      dac_valid_o,
  output logic signed [OUT_W-1:0]   dac_data_o
);

  localparam int FB_W = OUT_W + TAP_W + 1 + $clog2(NG) + 1;
  localparam int V_W  = FB_W + 1;

  thp_mode_e               mode;
  logic signed [OUT_W-1:0] level;
  logic signed [OUT_W-1:0] wrapped;
  logic signed [OUT_W-1:0] y_next;
  logic signed [FB_W-1:0]  fb;
  logic signed [V_W-1:0]   pre_mod;
  logic                    dac_valid_d;
  logic signed [OUT_W-1:0] dac_data_d;

  assign mode = thp_mode_e'(bypass_i);

  thp_symbol_map #(
    .M(M), .FRAC(FRAC), .IDX_W(IDX_W), .OUT_W(OUT_W)
  ) u_map (
    .idx_i   (sym_idx_i),
    .level_o (level)
  );

  thp_feedback_fir #(
    .NG(NG), .TAP_W(TAP_W), .Y_W(OUT_W), .FB_W(FB_W)
  ) u_fir (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_i      (tap_i),
    .shift_en_i (sym_valid_i),
    .y_i        (y_next),
    .fb_o       (fb)
  );

  assign pre_mod = V_W'(level) - V_W'(fb);

  thp_modulo_reduce #(
    .M(M), .FRAC(FRAC), .V_W(V_W), .OUT_W(OUT_W), .STAGES(MOD_STAGES)
  ) u_mod (
    .v_i (pre_mod),
    .y_o (wrapped)
  );

  always_comb begin
    y_next      = (mode == MODE_BYPASS) ? level : wrapped;
    dac_valid_d = sym_valid_i;
    dac_data_d  = sym_valid_i ? y_next : dac_data_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_valid_o <= 1'b0;
      dac_data_o  <= '0;
    end else begin
      dac_valid_o <= dac_valid_d;
      dac_data_o  <= dac_data_d;
    end
  end

endmodule

// File: rtl/thp_precoder_chk.sv
module thp_precoder_chk #(
  parameter int M     = 12,
  parameter int FRAC  = 4,
  parameter int IDX_W = 4,
  parameter int OUT_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bypass_i,
  input logic                    sym_valid_i,
  input logic [IDX_W-1:0]        sym_idx_i,
  input logic                    dac_valid_o,
  input logic signed [OUT_W-1:0] dac_data_o
);

  localparam int SCALE = 1 << FRAC;
  localparam int LIM   = M * SCALE;

  function automatic int want_level(input logic [IDX_W-1:0] idx);
    int i;
    i = int'(idx);
    if (i > M - 1) i = M - 1;
    return (2 * i - (M - 1)) * SCALE;
  endfunction

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid_i |=> dac_valid_o);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid_i |=> (!dac_valid_o && $stable(dac_data_o)));

  // R4
  window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_i && !bypass_i) |=> (int'(dac_data_o) >= -LIM && int'(dac_data_o) < LIM));

  // R5
  bypass_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid_i && bypass_i) |=> (int'(dac_data_o) == want_level($past(sym_idx_i))));

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!dac_valid_o && dac_data_o == '0));

endmodule

bind thp_precoder thp_precoder_chk #(
  .M(M), .FRAC(FRAC), .IDX_W(IDX_W), .OUT_W(OUT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bypass_i    (bypass_i),
  .sym_valid_i (sym_valid_i),
  .sym_idx_i   (sym_idx_i),
  .dac_valid_o (dac_valid_o),
  .dac_data_o  (dac_data_o)
);

// File: tb/test_thp_precoder.sv
module test_thp_precoder;

  localparam int CLK_PERIOD = 10;
  localparam int M      = 12;
  localparam int FRAC   = 4;
  localparam int NG     = 8;
  localparam int TAP_W  = 4;
  localparam int IDX_W  = 4;
  localparam int OUT_W  = 9;
  localparam int SC     = 16;
  localparam int LIM    = M * SC;
  localparam int WD_LIMIT = 20000;

  // vector table, zero coefficients (h1 = 1): bypass, index, expected integer level
  localparam int VEC_N = 13;
  localparam int VBYP [VEC_N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1};
  localparam int VIDX [VEC_N] = '{11, 0, 5, 11, 6, 11, 0, 6, 0, 3, 3, 11, 15};
  localparam int VEXP [VEC_N] = '{11, 2, -3, -10, 11, 0, -11, -12, 1, -6, -5, -8, 11};

  logic                      clk;
  logic                      rst_n;
  logic [(NG-1)*TAP_W-1:0]   tap;
  logic                      bypass;
  logic                      sym_valid;
  logic [IDX_W-1:0]          sym_idx;
  logic                      dac_valid;
  logic signed [OUT_W-1:0]   dac_data;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  int hm [1:NG];
  int yh [1:NG];

  thp_precoder i_thp_precoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .tap_i       (tap),
    .bypass_i    (bypass),
    .sym_valid_i (sym_valid),
    .sym_idx_i   (sym_idx),
    .dac_valid_o (dac_valid),
    .dac_data_o  (dac_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WD_LIMIT) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected <= %0d", cyc, WD_LIMIT);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int fold(input int v);
    int r;
    r = v;
    while (r >= LIM) r -= 2 * LIM;
    while (r < -LIM) r += 2 * LIM;
    return r;
  endfunction

  task automatic model_taps(input int g1, input int g2);
    int g [0:NG];
    for (int k = 0; k <= NG; k++) g[k] = 0;
    g[0] = 1; g[1] = g1; g[2] = g2;
    for (int k = 1; k <= NG; k++) begin
      hm[k] = g[k] + g[k-1];
      yh[k] = 0;
    end
  endtask

  task automatic model_step(input bit byp, input int idx, output int y);
    int i, x, fb;
    i = (idx > M - 1) ? M - 1 : idx;
    x = (2 * i - (M - 1)) * SC;
    if (byp) begin
      y = x;
    end else begin
      fb = 0;
      for (int k = 1; k <= NG; k++) fb += hm[k] * yh[k];
      y = fold(x - fb);
    end
    for (int k = NG; k >= 2; k--) yh[k] = yh[k-1];
    yh[1] = y;
  endtask

  task automatic do_reset(input logic [(NG-1)*TAP_W-1:0] t);
    @(negedge clk);
    rst_n = 1'b0;
    tap = t;
    sym_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(dac_valid), 0, "R7 valid in reset");
    check(int'(dac_data), 0, "R7 data in reset");
    rst_n = 1'b1;
  endtask

  task automatic send(input bit byp, input int idx);
    @(negedge clk);
    bypass = byp;
    sym_idx = IDX_W'(idx);
    sym_valid = 1'b1;
    @(negedge clk);
    sym_valid = 1'b0;
    check(int'(dac_valid), 1, "R2 valid after symbol");
  endtask

  initial begin
    logic [31:0] lfsr;
    int y_exp;
    int held;
    rst_n = 1'b0;
    tap = '0;
    bypass = 1'b0;
    sym_valid = 1'b0;
    sym_idx = '0;

    // table walk with zero coefficients: R1 R3 R4 R5 R6
    do_reset('0);
    for (int n = 0; n < VEC_N; n++) begin
      send(VBYP[n] != 0, VIDX[n]);
      check(int'(dac_data), VEXP[n] * SC, "R3 R4 R5 R6 table");
      if (n % 4 == 1) begin
        held = int'(dac_data);
        @(negedge clk);
        check(int'(dac_valid), 0, "R2 gap valid");
        check(int'(dac_data), held, "R2 gap hold");
      end
    end

    // non-trivial coefficients g1 = 1, g2 = -1: R3 R4 R6
    do_reset({20'h0, 4'hF, 4'h1});
    model_taps(1, -1);
    lfsr = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      bit byp;
      int idx;
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      idx = int'(lfsr[19:16]);
      byp = (n % 9 == 8);
      model_step(byp, idx, y_exp);
      send(byp, idx);
      check(int'(dac_data), y_exp, byp ? "R5 R1 bypass" : "R3 precode");
      if (!byp) begin
        check(int'(int'(dac_data) >= -LIM && int'(dac_data) < LIM), 1, "R4 window");
      end
      if (n % 7 == 3) @(negedge clk);
    end

    // reset clears history and reloads zero coefficients: R7
    do_reset('0);
    send(1'b0, 0);
    check(int'(dac_data), -11 * SC, "R7 history cleared");
    send(1'b0, 0);
    check(int'(dac_data), 0, "R7 coefficients reloaded");
    send(1'b1, 0);
    check(int'(dac_data), -11 * SC, "R1 lowest level");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule